// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for a four-beat burst on a synchronous memory bus. Two active-low address strobes can open a burst: a processor strobe and a controller strobe. An accepted strobe loads a full external address. After the first beat, an active-low advance input steps the two low address bits. Those bits wrap inside their aligned group of four words, and the upper bits do not move.

A mode input sets the beat order while the block runs. In linear order the low bits count up modulo four from the loaded value. In interleaved order each beat is the loaded low bits XORed with the beat number.

Every input is sampled on the rising clock edge. The address, the beat number and a burst-active flag all change one edge after the input that caused them. The cycle is selected only when all three chip selects are asserted. The processor strobe is gated more strictly than the controller strobe. The block releases its reset through a two-stage synchronizer.

Top module: `burst_seq`

## Requirements
- R1: While reset is applied, and for the synchronizer stages after it is released, addr_o is 0, beat_o is 0 and active_o is 0.
- R2: If ads_ctrl_n is 0 at an edge and the cycle is selected (sel0_n=0, sel1_n=0, sel2=1), then after that edge addr_o equals the sampled addr_i, beat_o is 0 and active_o is 1.
- R3: ads_proc_n=0 acts like an address strobe only while sel0_n=0, and then it loads the same way as in R2. While sel0_n=1 it is ignored, so addr_o, beat_o and active_o keep their values unless another input changes them.
- R4: An accepted strobe in a cycle that is not selected clears active_o and leaves addr_o and beat_o unchanged.
- R5: If no strobe is accepted, adv_n=0 and active_o=1, then beat_o increments modulo 4 at the edge. While active_o=0, adv_n has no effect.
- R6: With mode_lin=1, the low two bits of addr_o equal the loaded low bits plus beat_o, modulo 4.
- R7: With mode_lin=0, the low two bits of addr_o equal the loaded low bits XOR beat_o.
- R8: If both strobes are 1 and adv_n=1, then addr_o, beat_o and active_o hold.
- R9: addr_o bits above bit 1 change only at an edge where a strobe is accepted.
- R10: A strobe that is accepted together with adv_n=0 takes priority, so beat_o becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | External address loaded by a strobe |
| ads_proc_n | input | 1 | Processor address strobe, active low |
| ads_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel0_n | input | 1 | Primary chip select, active low |
| sel1_n | input | 1 | Second chip select, active low |
| sel2 | input | 1 | Third chip select, active high |
| mode_lin | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_o | output | ADDR_W | Current burst word address |
| beat_o | output | CNT_W | Beat position within the burst |
| active_o | output | 1 | Burst is open and may advance |

## Verification
Each state register reaches the ports one edge after the input that changes it, so the bench checks after every edge. A wrong beat count shows at once on beat_o and on the low bits of addr_o. The error shows differently in the two orders, which separates an adder fault from an XOR fault. A corrupted base register shows as upper address bits that move without a load. A wrong active flag shows at the next advance, as a step that should not happen or a step that does not happen.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_DESEL = 2'd2,
    ACT_STEP  = 2'd3
  } act_e;
endpackage

// File: rtl/burst_seq_rst.sv
module burst_seq_rst #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic ads_proc_n,
  input  logic ads_ctrl_n,
  input  logic adv_n,
  input  logic sel0_n,
  input  logic sel1_n,
  input  logic sel2,
  input  logic active,
  output act_e act
);
  logic proc_take;
  logic strobe;
  logic sel_all;

  always_comb begin
    // processor strobe only counts while the primary select is low
    proc_take = !ads_proc_n && !sel0_n;
    strobe    = proc_take || !ads_ctrl_n;
    sel_all   = !sel0_n && !sel1_n && sel2;
    if (strobe)                act = sel_all ? ACT_LOAD : ACT_DESEL;
    else if (!adv_n && active) act = ACT_STEP;
    else                       act = ACT_HOLD;
  end
endmodule

// File: rtl/burst_seq_cnt.sv
module burst_seq_cnt
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              srst_n,
  input  act_e              act,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              active_q
);
  logic [ADDR_W-1:0] base_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              active_d;
  logic              en;

  always_comb begin
    base_d   = base_q;
    cnt_d    = cnt_q;
    active_d = active_q;
    unique case (act)
      ACT_LOAD: begin
        base_d   = addr_i;
        cnt_d    = '0;
        active_d = 1'b1;
      end
      ACT_DESEL: active_d = 1'b0;
      ACT_STEP:  cnt_d    = cnt_q + CNT_W'(1);
      default: ;
    endcase
    en = (act != ACT_HOLD);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (en) begin
      base_q   <= base_d;
      cnt_q    <= cnt_d;
      active_q <= active_d;
    end
  end
endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map #(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              mode_lin,
  output logic [ADDR_W-1:0] addr
);
  logic [CNT_W-1:0] lin_lo;
  logic [CNT_W-1:0] ilv_lo;

  assign lin_lo = base[CNT_W-1:0] + cnt;

  for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
    assign ilv_lo[b] = base[b] ^ cnt[b];
  end

  assign addr = {base[ADDR_W-1:CNT_W], (mode_lin ? lin_lo : ilv_lo)};
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int CNT_W    = 2,
  parameter int RST_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ads_proc_n,
  input  logic              ads_ctrl_n,
  input  logic              adv_n,
  input  logic              sel0_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              mode_lin,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  beat_o,
  output logic              active_o
);
  logic              srst_n;
  act_e              act;
  logic [ADDR_W-1:0] base_q;

  burst_seq_rst #(.STAGES(RST_SYNC)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  burst_seq_ctrl u_ctrl (
    .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
    .sel0_n(sel0_n), .sel1_n(sel1_n), .sel2(sel2),
    .active(active_o), .act(act)
  );

  burst_seq_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .srst_n(srst_n), .act(act), .addr_i(addr_i),
    .base_q(base_q), .cnt_q(beat_o), .active_q(active_o)
  );

  burst_seq_map #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_map (
    .base(base_q), .cnt(beat_o), .mode_lin(mode_lin), .addr(addr_o)
  );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              ads_proc_n,
  input logic              ads_ctrl_n,
  input logic              adv_n,
  input logic              sel0_n,
  input logic              sel1_n,
  input logic              sel2,
  input logic              mode_lin,
  input logic [ADDR_W-1:0] addr_o,
  input logic [CNT_W-1:0]  beat_o,
  input logic              active_o
);
  logic take;
  logic sel_all;
  logic stepping;

  assign take     = (!ads_proc_n && !sel0_n) || !ads_ctrl_n;
  assign sel_all  = !sel0_n && !sel1_n && sel2;
  assign stepping = !take && !adv_n && active_o;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sel_all) |=> (addr_o == $past(addr_i)) && (beat_o == '0) && active_o);

  assert_proc_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_proc_n && sel0_n && ads_ctrl_n && adv_n) |=>
      ($stable(addr_o) && $stable(beat_o) && $stable(active_o)));

  assert_desel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !sel_all) |=> (!active_o && $stable(addr_o) && $stable(beat_o)));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stepping |=> (beat_o == CNT_W'($past(beat_o) + CNT_W'(1))));

  assert_linear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && mode_lin) |=>
      (addr_o[CNT_W-1:0] == CNT_W'($past(addr_o[CNT_W-1:0]) + CNT_W'(1))));

  assert_interleave_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && !mode_lin) |=>
      ((addr_o[CNT_W-1:0] ^ $past(addr_o[CNT_W-1:0])) == (beat_o ^ $past(beat_o))));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_proc_n && ads_ctrl_n && adv_n) |=>
      ($stable(addr_o) && $stable(beat_o) && $stable(active_o)));

  assert_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(addr_o[ADDR_W-1:CNT_W]));
endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(srst_n), .addr_i(addr_i), .ads_proc_n(ads_proc_n),
  .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n), .sel0_n(sel0_n), .sel1_n(sel1_n),
  .sel2(sel2), .mode_lin(mode_lin), .addr_o(addr_o), .beat_o(beat_o),
  .active_o(active_o)
);

// File: tb/burst_seq_tb.sv
module burst_seq_tb;
  localparam int AW = 18;
  localparam int NV = 19;

  typedef struct packed {
    logic          pn, cn, an, s0n, s1n, s2, lin;
    logic [AW-1:0] a;
    logic [AW-1:0] ea;
    logic [1:0]    eb;
    logic          eact;
    logic [3:0]    req;
  } vec_t;

  // pn cn an s0n s1n s2 lin addr -> exp addr, beat, active, requirement
  localparam vec_t VECS [NV] = '{
    '{1,0,1,0,0,1,1,18'h12345,18'h12345,2'd0,1,4'd2},  // R2 controller load
    '{1,1,0,0,0,1,1,18'h0,18'h12346,2'd1,1,4'd6},      // R6 linear
    '{1,1,0,0,0,1,1,18'h0,18'h12347,2'd2,1,4'd6},      // R6
    '{1,1,0,0,0,1,1,18'h0,18'h12344,2'd3,1,4'd6},      // R6 wrap in group
    '{1,1,0,0,0,1,1,18'h0,18'h12345,2'd0,1,4'd6},      // R6 back to start
    '{1,1,1,0,0,1,1,18'h0,18'h12345,2'd0,1,4'd8},      // R8 suspend
    '{0,1,1,1,0,1,1,18'h0,18'h12345,2'd0,1,4'd3},      // R3 proc ignored
    '{0,1,1,0,0,1,0,18'h2ABCE,18'h2ABCE,2'd0,1,4'd3},  // R3 proc load
    '{1,1,0,0,0,1,0,18'h0,18'h2ABCF,2'd1,1,4'd7},      // R7 interleaved
    '{1,1,0,0,0,1,0,18'h0,18'h2ABCC,2'd2,1,4'd7},      // R7
    '{1,1,0,0,0,1,0,18'h0,18'h2ABCD,2'd3,1,4'd7},      // R7
    '{1,0,1,0,0,0,0,18'h11111,18'h2ABCD,2'd3,0,4'd4},  // R4 deselect
    '{1,1,0,0,0,1,0,18'h0,18'h2ABCD,2'd3,0,4'd5},      // R5 no step inactive
    '{1,0,0,0,0,1,1,18'h3FFFF,18'h3FFFF,2'd0,1,4'd10}, // R10 load beats adv
    '{1,1,0,0,0,1,1,18'h0,18'h3FFFC,2'd1,1,4'd9},      // R9 upper unchanged
    '{0,0,1,1,0,1,1,18'h7,18'h3FFFC,2'd1,0,4'd4},      // R4 ctrl, sel0 off
    '{0,1,0,0,1,1,1,18'h100,18'h3FFFC,2'd1,0,4'd4},    // R4 proc, sel1 off
    '{0,1,0,0,0,1,1,18'h102,18'h102,2'd0,1,4'd10},     // R10 proc with adv
    '{1,1,0,0,0,1,1,18'h0,18'h103,2'd1,1,4'd6}         // R6
  };

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          ads_proc_n, ads_ctrl_n, adv_n, sel0_n, sel1_n, sel2, mode_lin;
  logic [AW-1:0] addr_o;
  logic [1:0]    beat_o;
  logic          active_o;
  int            errors;
  int            checks;
  logic          done;

  burst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ads_proc_n(ads_proc_n),
    .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n), .sel0_n(sel0_n), .sel1_n(sel1_n),
    .sel2(sel2), .mode_lin(mode_lin), .addr_o(addr_o), .beat_o(beat_o),
    .active_o(active_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [AW-1:0] ea,
                       input logic [1:0] eb, input logic eact);
    checks++;
    if (addr_o !== ea || beat_o !== eb || active_o !== eact) begin
      errors++;
      $display("FAIL %s: got addr=%h beat=%0d act=%0b, expected addr=%h beat=%0d act=%0b",
               tag, addr_o, beat_o, active_o, ea, eb, eact);
    end
  endtask

  task automatic idle();
    ads_proc_n = 1; ads_ctrl_n = 1; adv_n = 1;
    sel0_n = 0; sel1_n = 0; sel2 = 1; mode_lin = 1; addr_i = '0;
  endtask

  initial begin
    errors = 0; checks = 0; done = 0;
    rst_n = 0;
    idle();
    repeat (3) @(posedge clk);
    #1 check("R1 reset", '0, 2'd0, 1'b0);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    #1 check("R1 after release", '0, 2'd0, 1'b0);
    // R5: advance right after reset has no effect
    @(negedge clk) adv_n = 0;
    @(posedge clk); #1 check("R5 adv inactive", '0, 2'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ads_proc_n = VECS[i].pn; ads_ctrl_n = VECS[i].cn; adv_n = VECS[i].an;
      sel0_n = VECS[i].s0n; sel1_n = VECS[i].s1n; sel2 = VECS[i].s2;
      mode_lin = VECS[i].lin; addr_i = VECS[i].a;
      @(posedge clk); #1
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            VECS[i].ea, VECS[i].eb, VECS[i].eact);
    end

    // R1: reset in mid-burst returns everything to zero
    @(negedge clk) idle(); adv_n = 0; rst_n = 0;
    #1 check("R1 mid-burst reset", '0, 2'd0, 1'b0);
    @(negedge clk) rst_n = 1; idle();
    repeat (4) @(posedge clk);
    // R7: interleaved from low bits 11 runs 3,2,1,0
    @(negedge clk) ads_ctrl_n = 0; mode_lin = 0; addr_i = 18'h00AB7;
    @(posedge clk); #1 check("R7 load 11", 18'h00AB7, 2'd0, 1'b1);
    @(negedge clk) idle(); mode_lin = 0; adv_n = 0;
    @(posedge clk); #1 check("R7 beat1", 18'h00AB6, 2'd1, 1'b1);
    @(posedge clk); #1 check("R7 beat2", 18'h00AB5, 2'd2, 1'b1);
    @(posedge clk); #1 check("R7 beat3", 18'h00AB4, 2'd3, 1'b1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule